// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the timing of an I2C serial clock from a fast input clock. A programmable prescaler divides the input clock into a slower module tick, and a small state machine counts those ticks to hold the serial clock low for one programmed span and released for another. The line is driven open-drain style. The block only ever asks for SCL to be pulled low, and it reads the actual line level back on a sense input. If another device is still holding the line low, the released phase does not advance. This gives clock stretching and lets a slower master on the same wire set the pace.

The three timing values (prescale, low span, high span) sit in configuration registers that accept writes only while the module enable is low. While the enable is low the module is held in reset: the line is released and every counter is cleared. Raising the enable starts the prescaler and the first low phase together, so new settings always apply from a clean start. A combinational flag reports when the programmed prescaler would put the module tick outside the permitted 6.7 to 13.3 MHz window for the input frequency given as a parameter.

State machine: `PH_OFF` (held in reset, line released) goes to `PH_LOW` when the enable is high. `PH_LOW` (line driven low, counting ticks) goes to `PH_WAIT_HI` on the last low tick. `PH_WAIT_HI` (line released, waiting for the sensed line to read high) goes to `PH_HIGH` once the sense input reads high. `PH_HIGH` (line released, counting ticks only while the sense input is high) goes to `PH_LOW` on the last high tick. Every state goes to `PH_OFF` when the enable drops.

Top module: `i2c_sclk_gen`

## Requirements
- R1: While `mod_en` is 0, `scl_pull_low` is 0 and `mod_tick` is 0, and all counters are cleared.
- R2: A write with `cfg_we`=1 is captured only when `mod_en` is 0 at that clock edge. `cfg_sel` selects the target: 0 = prescale, 1 = low span, 2 = high span, 3 = none. A write made while enabled is ignored, including a write in the same cycle the enable rises.
- R3: While enabled, `mod_tick` pulses for one cycle every (prescale + 1) input clock cycles.
- R4: Each low phase after the first lasts exactly (low span + 6) × (prescale + 1) input clock cycles.
- R5: With no external hold on the line, each high phase lasts exactly (high span + 6) × (prescale + 1) input clock cycles.
- R6: After a low phase the line stays released, and the high count does not start until `scl_sense` reads 1. With prescale 0 and the line held low for K released cycles, the released time is K + high span + 5 cycles.
- R7: In the high phase, a cycle in which `scl_sense` is 0 is not counted. With prescale 0, a hold of M cycles lengthens the high phase to high span + 6 + M cycles.
- R8: `cfg_range_err` is 1 exactly when IN_CLK_KHZ < 6700 × (prescale + 1) or IN_CLK_KHZ > 13300 × (prescale + 1), using the stored prescale value.
- R9: The cycle after the enable is sampled high, `scl_pull_low` is 1, so every run begins with a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast module input clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mod_en | input | 1 | Module enable; 0 holds the module in reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 prescale, 1 low span, 2 high span |
| cfg_wdata | input | WD_W (8) | Configuration write data |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release |
| mod_tick | output | 1 | One-cycle module clock tick for the bit engine |
| cfg_range_err | output | 1 | Stored prescale puts the module tick outside its window |

## Verification
Two events can land on the same clock edge. The first pair is a prescaler tick and the rise of the sensed line in the wait state. With prescale 0 every cycle is a tick, so that tick must be counted as the first high tick; otherwise each high phase comes out one cycle long. The bench provokes this across the whole sweep, and with an external hold released at chosen cycles, and judges it by exact released-phase lengths. The second pair is a configuration write and the rising enable. The bench drives both in the same cycle, and the unchanged range flag and tick period show that the write was dropped.

// File: rtl/i2c_sclk_pkg.sv
package i2c_sclk_pkg;

    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,
        PH_LOW     = 2'd1,
        PH_WAIT_HI = 2'd2,
        PH_HIGH    = 2'd3
    } sclk_phase_t;

    localparam logic [1:0] SEL_PRESCALE = 2'd0;
    localparam logic [1:0] SEL_LOW_SPAN = 2'd1;
    localparam logic [1:0] SEL_HI_SPAN  = 2'd2;

    // Fixed extra ticks added to each programmed span.
    localparam int SPAN_EXTRA = 6;

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] ratio_m1,
    output logic             tick
);

    logic [PSC_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || cnt_q == ratio_m1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == ratio_m1);

    // R3: the count never passes the programmed ratio.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q <= ratio_m1));

    // R1: the counter is cleared one cycle after the enable is low.
    a_r1_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm
    import i2c_sclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             scl_sense,
    input  logic [DIV_W-1:0] low_span,
    input  logic [DIV_W-1:0] high_span,
    output logic             pull_low
);

    localparam int CNT_W = DIV_W + 1;

    sclk_phase_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lo_last, hi_last;
    logic              lo_done, hi_done;

    assign lo_last = {1'b0, low_span}  + CNT_W'(SPAN_EXTRA - 1);
    assign hi_last = {1'b0, high_span} + CNT_W'(SPAN_EXTRA - 1);
    assign lo_done = tick && (cnt_q == lo_last);
    assign hi_done = tick && scl_sense && (cnt_q == hi_last);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_OFF:     if (en)        state_d = PH_LOW;
            PH_LOW:     if (lo_done)   state_d = PH_WAIT_HI;
            PH_WAIT_HI: if (scl_sense) state_d = PH_HIGH;
            PH_HIGH:    if (hi_done)   state_d = PH_LOW;
            default:                   state_d = PH_OFF;
        endcase
        if (!en) state_d = PH_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            // A tick in the wait cycle already counts toward the high phase.
            cnt_q <= (state_d == PH_HIGH && tick) ? CNT_W'(1) : '0;
        end else if (state_q == PH_LOW && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (state_q == PH_HIGH && tick && scl_sense) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        pull_low = 1'b0;
        unique case (state_q)
            PH_LOW:  pull_low = 1'b1;
            default: pull_low = 1'b0;
        endcase
    end

    // R6: a low phase is always followed by the wait state, never straight by high.
    a_r6_wait_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW && en) |=> (state_q != PH_HIGH));

    // R7: the high count holds while the sensed line is low.
    a_r7_high_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HIGH && !scl_sense && en) |=> $stable(cnt_q));

    // R4: the low phase ends only on a prescaler tick.
    a_r4_low_exit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW && en && !tick) |=> (state_q == PH_LOW));

    // R9: enabling from reset always enters the low phase.
    a_r9_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_OFF && en) |=> (state_q == PH_LOW));

endmodule

// File: rtl/i2c_sclk_gen.sv
module i2c_sclk_gen
    import i2c_sclk_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int DIV_W       = 8,
    parameter int IN_CLK_KHZ  = 100000,
    parameter int MOD_MIN_KHZ = 6700,
    parameter int MOD_MAX_KHZ = 13300,
    localparam int WD_W       = (PSC_W > DIV_W) ? PSC_W : DIV_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mod_en,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [WD_W-1:0] cfg_wdata,
    input  logic            scl_sense,
    output logic            scl_pull_low,
    output logic            mod_tick,
    output logic            cfg_range_err
);

    logic [PSC_W-1:0] psc_q;
    logic [DIV_W-1:0] low_q, high_q;
    logic [31:0]      ratio;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q  <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else if (cfg_we && !mod_en) begin
            unique case (cfg_sel)
                SEL_PRESCALE: psc_q  <= cfg_wdata[PSC_W-1:0];
                SEL_LOW_SPAN: low_q  <= cfg_wdata[DIV_W-1:0];
                SEL_HI_SPAN:  high_q <= cfg_wdata[DIV_W-1:0];
                default:      ;
            endcase
        end
    end

    assign ratio = 32'(psc_q) + 32'd1;
    assign cfg_range_err = (32'(IN_CLK_KHZ) < 32'(MOD_MIN_KHZ) * ratio) ||
                           (32'(IN_CLK_KHZ) > 32'(MOD_MAX_KHZ) * ratio);

    sclk_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mod_en),
        .ratio_m1 (psc_q),
        .tick     (mod_tick)
    );

    sclk_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mod_en),
        .tick      (mod_tick),
        .scl_sense (scl_sense),
        .low_span  (low_q),
        .high_span (high_q),
        .pull_low  (scl_pull_low)
    );

    // R2: settings hold still across any edge at which the module was enabled.
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mod_en) |-> ($stable(psc_q) && $stable(low_q) && $stable(high_q)));

    // R1: one cycle after the enable is low the line is released.
    a_r1_released: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> !scl_pull_low);

endmodule

// File: tb/sim_i2c_sclk_gen.sv
module sim_i2c_sclk_gen;

    localparam int IN_KHZ = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       force_low = 1'b0;
    logic       scl_sense;
    logic       scl_pull_low, mod_tick, cfg_range_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    assign scl_sense = ~(scl_pull_low | force_low);

    i2c_sclk_gen #(.IN_CLK_KHZ(IN_KHZ)) u0 (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .scl_sense(scl_sense),
        .scl_pull_low(scl_pull_low), .mod_tick(mod_tick),
        .cfg_range_err(cfg_range_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_err(input int p);
        return ((IN_KHZ < 6700 * (p + 1)) || (IN_KHZ > 13300 * (p + 1))) ? 1 : 0;
    endfunction

    task automatic wr(input logic [1:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_level(input logic v);
        for (int i = 0; i < 20000 && scl_pull_low != v; i++) @(negedge clk);
    endtask

    task automatic run_len(input logic v, output int n);
        n = 0;
        while (scl_pull_low == v && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic tick_period(output int n);
        for (int i = 0; i < 1000 && !mod_tick; i++) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!mod_tick && n < 1000);
    endtask

    task automatic setup(input int p, input int lo, input int hi);
        @(negedge clk);
        mod_en = 1'b0;
        wr(2'd0, p); wr(2'd1, lo); wr(2'd2, hi);
        @(negedge clk);
        mod_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n, tot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pull_low in reset", int'(scl_pull_low), 0);
        check("R1 tick in reset", int'(mod_tick), 0);

        // R8: range flag across prescale values, including both window edges
        for (int p = 0; p < 20; p++) begin
            wr(2'd0, p);
            @(negedge clk);
            check($sformatf("R8 range flag p=%0d", p), int'(cfg_range_err), exp_err(p));
        end

        // Sweep of the timing arithmetic: R3, R4, R5, R9
        for (int p = 0; p < 4; p++) begin
            for (int li = 0; li < 3; li++) begin
                for (int hj = 0; hj < 3; hj++) begin
                    int lo, hi;
                    lo = (li == 0) ? 0 : (li == 1) ? 2 : 5;
                    hi = (hj == 0) ? 0 : (hj == 1) ? 1 : 4;
                    setup(p, lo, hi);
                    check($sformatf("R9 start low p=%0d", p), int'(scl_pull_low), 1);
                    wait_level(1'b0);
                    wait_level(1'b1);
                    run_len(1'b1, n);
                    check($sformatf("R4 low len p=%0d l=%0d", p, lo), n, (lo + 6) * (p + 1));
                    run_len(1'b0, n);
                    check($sformatf("R5 high len p=%0d h=%0d", p, hi), n, (hi + 6) * (p + 1));
                    tick_period(n);
                    check($sformatf("R3 tick period p=%0d", p), n, p + 1);
                end
            end
        end

        // R1: dropping the enable mid-run releases the line and stops ticks
        @(negedge clk);
        mod_en = 1'b0;
        tot = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            tot += int'(scl_pull_low) + int'(mod_tick);
        end
        check("R1 quiet after disable", tot, 0);

        // R2: writes while enabled, and in the enabling cycle, are dropped
        wr(2'd0, 7);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'd6; mod_en = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R2 write at enable edge dropped", int'(cfg_range_err), 0);
        wr(2'd0, 20);
        check("R2 write while enabled dropped", int'(cfg_range_err), 0);
        tick_period(n);
        check("R2 tick period unchanged", n, 8);
        @(negedge clk);
        mod_en = 1'b0;
        @(negedge clk);
        check("R2 stored value after disable", int'(cfg_range_err), 0);

        // R6: hold the line low through the wait state (prescale 0)
        for (int k = 1; k <= 5; k += 2) begin
            setup(0, 1, 2);
            force_low = 1'b1;
            wait_level(1'b0);
            tot = 1;
            for (int i = 1; i < k; i++) begin
                @(negedge clk);
                tot++;
            end
            force_low = 1'b0;
            @(negedge clk);
            run_len(1'b0, n);
            check($sformatf("R6 stretched high k=%0d", k), tot + n, k + 2 + 5);
        end

        // R7: pull the line low in the middle of the high count (prescale 0)
        for (int m = 1; m <= 4; m += 3) begin
            setup(0, 0, 2);
            wait_level(1'b0);
            wait_level(1'b1);
            wait_level(1'b0);
            @(negedge clk);
            @(negedge clk);
            tot = 3;
            force_low = 1'b1;
            for (int i = 0; i < m; i++) begin
                @(negedge clk);
                tot++;
            end
            force_low = 1'b0;
            @(negedge clk);
            run_len(1'b0, n);
            check($sformatf("R7 stalled high m=%0d", m), tot + n, 2 + 6 + m);
        end

        mod_en = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule